// File: doc/BRIEF.md
# Card Host Descriptor DMA Engine

This block moves card data buffers under the control of descriptors kept in system memory. Software sets a start address for the descriptor chain, a gap between descriptors and a burst-size code, then sets the enable bit. The engine reads each descriptor through a word-wide memory port. If the descriptor is marked as owned by the engine, the engine streams the buffer's beats onto a host bus in bursts of the coded size, shortening only the final burst. It then writes the descriptor back with the ownership bit cleared and moves on to the next descriptor.

A descriptor that is not owned makes the engine suspend. It stays suspended until software writes the poll bit of the control register. The poll bit makes the engine read the same descriptor again. The burst-size code is kept in a separate threshold register and appears read-only inside the control register. A separate register bit drives the card's hardware reset line.

Descriptor layout: word 0 holds the ownership flag in bit 31, the end-of-ring flag in bit 30 and the buffer length in beats in bits 15:0. Word 1 holds the buffer byte address.

Top module: `cdma_engine`

## Requirements
- R1: After reset, the control register reads 0x00000000, the card-reset register reads 0x00000001, the threshold and base registers read 0, card_rst_n is high, and there is no memory or bus activity.
- R2: Control register (index 0) layout: bit 7 is enable and bits 6:2 are the skip length, both read/write. Bit 31 is the poll command, which is write-only and reads 0. All other unlisted bits read 0.
- R3: Control register bits 10:8 always read the burst code held in threshold register (index 2) bits 30:28. Writes to bits 10:8 of the control register are ignored.
- R4: Burst code n gives 1 beat for n=0 and 2^(n+1) beats otherwise (000=1 up to 111=256). Each burst is announced by bus_first, and its bus_len is the smaller of that size and the beats remaining in the buffer.
- R5: A beat completes when bus_valid and bus_ready are both high. Successive beats of a buffer step the address by 4. While a beat waits, bus_valid and bus_addr hold.
- R6: A descriptor is fetched as two word reads at its address and its address plus 4, each answered one cycle later on mem_rdata. Word 0 is read first. Word 1 is not read when word 0 is not owned.
- R7: The base register (index 3) stores an address with bits 1:0 forced to 0. Enabling from idle starts at the base address. The next descriptor sits at the current address + 8 + 4×skip, or at the base address when the end-of-ring flag is set.
- R8: After the last beat of a buffer, the engine writes word 0 back with bit 31 cleared and every other bit unchanged. A zero-length buffer is written back with no beats.
- R9: A fetched descriptor whose bit 31 is clear suspends the engine. The engine does no reads until a poll write, which makes it read the same descriptor again. A poll while disabled has no effect.
- R10: Clearing enable during a transfer lets the pending beat complete, then the engine stops without writing back. After that, setting enable again starts from the base address.
- R11: Card-reset register (index 1) bit 0 drives card_rst_n. Writing 0 holds the card in reset and writing 1 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| card_rst_n | output | 1 | Card hardware reset, low = held in reset |
| mem_rd_en | output | 1 | Descriptor word read request |
| mem_wr_en | output | 1 | Descriptor write-back request |
| mem_addr | output | ADDR_W | Descriptor word byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd_en |
| bus_valid | output | 1 | Data beat offered on host bus |
| bus_ready | input | 1 | Host bus accepts the beat |
| bus_first | output | 1 | Beat is the first of a burst |
| bus_len | output | LEN_W | Burst length in beats, valid with bus_first |
| bus_addr | output | ADDR_W | Beat byte address |

## Verification
All eight burst codes are tried against buffer lengths of 0, 1, 7, 37 and one more than the burst size. This separates a wrong code decode, a final burst that is not shortened, and an off-by-one in beat counting. Runs alternate between an always-ready bus and a stalling bus, which shows whether beats are dropped or duplicated under back-pressure. Chains with skip lengths 2 and 31 check the stride and show that the skipped words are never read. A descriptor that is made valid while the engine is suspended, with and without a poll, separates a poll-driven resume from spontaneous re-polling. A disable issued while a beat is stalled tells a clean stop apart from an abandoned beat or a spurious write-back.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_RD0  = 3'd1,
      S_RD1  = 3'd2,
      S_RD2  = 3'd3,
      S_XFER = 3'd4,
      S_WB   = 3'd5,
      S_SUSP = 3'd6
   } cdma_state_e;

   localparam int OWN_POS    = 31;
   localparam int RING_POS   = 30;
   localparam int POLL_POS   = 31;
   localparam int THR_LSB    = 28;
   localparam int WORD_BYTES = 4;
   localparam int DESC_BYTES = 8;

   localparam logic [1:0] REG_MODE = 2'd0;
   localparam logic [1:0] REG_CRST = 2'd1;
   localparam logic [1:0] REG_THR  = 2'd2;
   localparam logic [1:0] REG_BASE = 2'd3;

endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
   import cdma_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              eng_en,
   output logic [4:0]        skip_len,
   output logic [2:0]        burst_enc,
   output logic [ADDR_W-1:0] base_addr,
   output logic              poll,
   output logic              card_rst_n
);

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("cdma_regs: ADDR_W must lie in 8..32");
      end
   endgenerate

   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_en     <= 1'b0;
         skip_len   <= '0;
         burst_enc  <= '0;
         base_addr  <= '0;
         card_rst_n <= 1'b1;
      end else if (wr_en) begin
         case (addr)
            REG_MODE: begin
               eng_en   <= wdata[7];
               skip_len <= wdata[6:2];
            end
            REG_CRST: card_rst_n <= wdata[0];
            REG_THR:  burst_enc  <= wdata[THR_LSB+2:THR_LSB];
            REG_BASE: base_addr  <= {wdata[ADDR_W-1:2], 2'b00};
            default: ;
         endcase
      end
   end

   assign poll = wr_en && (addr == REG_MODE) && wdata[POLL_POS];

   always_comb begin
      rdata = '0;
      case (addr)
         REG_MODE: begin
            rdata[10:8] = burst_enc;
            rdata[7]    = eng_en;
            rdata[6:2]  = skip_len;
         end
         REG_CRST: rdata[0] = card_rst_n;
         REG_THR:  rdata[THR_LSB+2:THR_LSB] = burst_enc;
         REG_BASE: rdata[ADDR_W-1:0] = base_addr;
         default: ;
      endcase
   end

endmodule

// File: rtl/cdma_burst_sizer.sv
module cdma_burst_sizer #(
   parameter int LEN_W        = 16,
   parameter bit SHIFT_DECODE = 1'b1
) (
   input  logic [2:0]       enc,
   input  logic [LEN_W-1:0] remaining,
   output logic [LEN_W-1:0] burst_len
);

   generate
      if (LEN_W < 9 || LEN_W > 30) begin : g_bad_len_w
         $error("cdma_burst_sizer: LEN_W must lie in 9..30");
      end
   endgenerate

   logic [8:0] full;

   generate
      if (SHIFT_DECODE) begin : g_shift
         always_comb begin
            if (enc == 3'd0) full = 9'd1;
            else             full = 9'd1 << ({1'b0, enc} + 4'd1);
         end
      end else begin : g_table
         always_comb begin
            case (enc)
               3'd0:    full = 9'd1;
               3'd1:    full = 9'd4;
               3'd2:    full = 9'd8;
               3'd3:    full = 9'd16;
               3'd4:    full = 9'd32;
               3'd5:    full = 9'd64;
               3'd6:    full = 9'd128;
               default: full = 9'd256;
            endcase
         end
      end
   endgenerate

   logic [LEN_W-1:0] full_w;
   assign full_w    = LEN_W'(full);
   assign burst_len = (remaining < full_w) ? remaining : full_w;

endmodule

// File: rtl/cdma_fetch_fsm.sv
module cdma_fetch_fsm
   import cdma_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int LEN_W        = 16,
   parameter bit SHIFT_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_en,
   input  logic [4:0]        skip_len,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              poll,
   input  logic [2:0]        burst_enc,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic              bus_first,
   output logic [LEN_W-1:0]  bus_len,
   output logic [ADDR_W-1:0] bus_addr
);

   cdma_state_e       st;
   logic [ADDR_W-1:0] cur;
   logic [31:0]       w0;
   logic [ADDR_W-1:0] buf_a;
   logic [LEN_W-1:0]  rem;
   logic [LEN_W-1:0]  blft;
   logic [LEN_W-1:0]  burst_len;
   logic [ADDR_W-1:0] next_desc;

   cdma_burst_sizer #(
      .LEN_W       (LEN_W),
      .SHIFT_DECODE(SHIFT_DECODE)
   ) u_sizer (
      .enc      (burst_enc),
      .remaining(rem),
      .burst_len(burst_len)
   );

   assign next_desc = w0[RING_POS] ? base_addr
                    : cur + ADDR_W'(DESC_BYTES) + ADDR_W'({skip_len, 2'b00});

   always_comb begin
      mem_rd_en = 1'b0;
      mem_wr_en = 1'b0;
      mem_addr  = cur;
      mem_wdata = w0 & ~(32'h1 << OWN_POS);
      case (st)
         S_RD0: mem_rd_en = eng_en;
         S_RD1: begin
            mem_rd_en = eng_en && mem_rdata[OWN_POS];
            mem_addr  = cur + ADDR_W'(WORD_BYTES);
         end
         S_WB:  mem_wr_en = 1'b1;
         default: ;
      endcase
   end

   assign bus_valid = (st == S_XFER);
   assign bus_first = bus_valid && (blft == '0);
   assign bus_len   = burst_len;
   assign bus_addr  = buf_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         cur   <= '0;
         w0    <= '0;
         buf_a <= '0;
         rem   <= '0;
         blft  <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (eng_en) begin
                  cur <= base_addr;
                  st  <= S_RD0;
               end
            end
            S_RD0: st <= eng_en ? S_RD1 : S_IDLE;
            S_RD1: begin
               if (!eng_en) st <= S_IDLE;
               else begin
                  w0 <= mem_rdata;
                  st <= mem_rdata[OWN_POS] ? S_RD2 : S_SUSP;
               end
            end
            S_RD2: begin
               if (!eng_en) st <= S_IDLE;
               else begin
                  buf_a <= mem_rdata[ADDR_W-1:0];
                  rem   <= w0[LEN_W-1:0];
                  blft  <= '0;
                  st    <= (w0[LEN_W-1:0] == '0) ? S_WB : S_XFER;
               end
            end
            S_XFER: begin
               if (bus_ready) begin
                  rem   <= rem - 1'b1;
                  buf_a <= buf_a + ADDR_W'(WORD_BYTES);
                  blft  <= ((blft == '0) ? burst_len : blft) - 1'b1;
                  if (!eng_en)              st <= S_IDLE;
                  else if (rem == LEN_W'(1)) st <= S_WB;
               end
            end
            S_WB: begin
               cur <= next_desc;
               st  <= eng_en ? S_RD0 : S_IDLE;
            end
            S_SUSP: begin
               if (!eng_en)  st <= S_IDLE;
               else if (poll) st <= S_RD0;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cdma_engine.sv
module cdma_engine #(
   parameter int ADDR_W       = 16,
   parameter int LEN_W        = 16,
   parameter bit SHIFT_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              card_rst_n,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic              bus_first,
   output logic [LEN_W-1:0]  bus_len,
   output logic [ADDR_W-1:0] bus_addr
);

   logic              eng_en;
   logic [4:0]        skip_len;
   logic [2:0]        burst_enc;
   logic [ADDR_W-1:0] base_addr;
   logic              poll;

   cdma_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .eng_en    (eng_en),
      .skip_len  (skip_len),
      .burst_enc (burst_enc),
      .base_addr (base_addr),
      .poll      (poll),
      .card_rst_n(card_rst_n)
   );

   cdma_fetch_fsm #(
      .ADDR_W      (ADDR_W),
      .LEN_W       (LEN_W),
      .SHIFT_DECODE(SHIFT_DECODE)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .eng_en   (eng_en),
      .skip_len (skip_len),
      .base_addr(base_addr),
      .poll     (poll),
      .burst_enc(burst_enc),
      .mem_rd_en(mem_rd_en),
      .mem_wr_en(mem_wr_en),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .bus_valid(bus_valid),
      .bus_ready(bus_ready),
      .bus_first(bus_first),
      .bus_len  (bus_len),
      .bus_addr (bus_addr)
   );

endmodule

// File: rtl/cdma_engine_chk.sv
module cdma_engine_chk #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              card_rst_n,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic              bus_first,
   input logic [LEN_W-1:0]  bus_len,
   input logic [ADDR_W-1:0] bus_addr
);

   logic unused_chk;
   assign unused_chk = ^{reg_wdata, mem_addr, mem_wdata};

   a_r2_mode_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> (reg_rdata[31:11] == '0));

   a_r4_burst_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      bus_first |-> (bus_len != '0 && bus_len <= LEN_W'(256)));

   a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_first)));

   a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en || mem_wr_en) |-> (mem_addr[1:0] == 2'b00));

   a_r6_no_fetch_during_beat: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !(mem_rd_en || mem_wr_en));

   a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   a_r8_writeback_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> !mem_wdata[31]);

   a_r11_card_reset_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1) |=> (card_rst_n == $past(reg_wdata[0])));

endmodule

bind cdma_engine cdma_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .card_rst_n(card_rst_n),
   .mem_rd_en (mem_rd_en),
   .mem_wr_en (mem_wr_en),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .bus_valid (bus_valid),
   .bus_ready (bus_ready),
   .bus_first (bus_first),
   .bus_len   (bus_len),
   .bus_addr  (bus_addr)
);

// File: tb/cdma_engine_tb.sv
module cdma_engine_tb;
   localparam int ADDR_W = 16;
   localparam int LEN_W  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              reg_wr = 1'b0;
   logic [1:0]        reg_addr = 2'd0;
   logic [31:0]       reg_wdata = 32'd0;
   logic [31:0]       reg_rdata;
   logic              card_rst_n;
   logic              mem_rd_en, mem_wr_en;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_wdata, mem_rdata;
   logic              bus_valid, bus_ready, bus_first;
   logic [LEN_W-1:0]  bus_len;
   logic [ADDR_W-1:0] bus_addr;

   cdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_rst_n(card_rst_n),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .bus_valid(bus_valid),
      .bus_ready(bus_ready), .bus_first(bus_first), .bus_len(bus_len),
      .bus_addr(bus_addr)
   );

   int checks = 0;
   int errors = 0;

   // ready pattern: 0 always ready, 1 stalling pattern, 2 manual
   int   rmode = 0;
   logic manual_ready = 1'b0;
   int   stall_cnt = 0;
   always @(negedge clk) stall_cnt <= stall_cnt + 1;
   assign bus_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? ((stall_cnt % 3) != 0) : manual_ready;

   // memory model and logger
   logic [31:0]       mem [0:63];
   logic [31:0]       rdq = 32'd0;
   logic              tb_wr = 1'b0;
   logic [5:0]        tb_wa = 6'd0;
   logic [31:0]       tb_wd = 32'd0;
   logic              log_clr = 1'b0;
   logic              mem_init = 1'b0;
   int                rd_cnt [0:63];
   int                nbeats = 0;
   int                nbursts = 0;
   logic [ADDR_W-1:0] beat_log [0:1023];
   logic [LEN_W-1:0]  burst_log [0:511];

   assign mem_rdata = rdq;

   always @(posedge clk) begin
      if (mem_init) begin
         for (int i = 0; i < 64; i++) mem[i] <= 32'd0;
      end else begin
         if (mem_wr_en) mem[mem_addr[7:2]] <= mem_wdata;
         if (tb_wr)     mem[tb_wa] <= tb_wd;
      end
      if (mem_rd_en) rdq <= mem[mem_addr[7:2]];
      if (log_clr) begin
         nbeats  <= 0;
         nbursts <= 0;
         for (int i = 0; i < 64; i++) rd_cnt[i] <= 0;
      end else begin
         if (mem_rd_en) rd_cnt[mem_addr[7:2]] <= rd_cnt[mem_addr[7:2]] + 1;
         if (bus_valid && bus_ready) begin
            if (nbeats < 1024) beat_log[nbeats] <= bus_addr;
            nbeats <= nbeats + 1;
            if (bus_first) begin
               if (nbursts < 512) burst_log[nbursts] <= bus_len;
               nbursts <= nbursts + 1;
            end
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_word(input int idx, input logic [31:0] d);
      @(negedge clk);
      tb_wr = 1'b1; tb_wa = idx[5:0]; tb_wd = d;
      @(negedge clk);
      tb_wr = 1'b0;
   endtask

   task automatic clear_logs;
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
   endtask

   task automatic wait_quiet;
      int q;
      int t;
      q = 0; t = 0;
      while (q < 6 && t < 20000) begin
         @(negedge clk);
         t++;
         if (mem_rd_en || mem_wr_en || bus_valid) q = 0;
         else q++;
      end
   endtask

   function automatic logic [31:0] desc0(input bit own, input bit ring, input int len);
      return {own, ring, 14'd0, len[15:0]};
   endfunction

   function automatic int enc_beats(input int e);
      return (e == 0) ? 1 : (1 << (e + 1));
   endfunction

   task automatic run_single(input int e, input int len, input int mode);
      int full;
      int rem;
      int k;
      int bad;
      int b;
      logic [ADDR_W-1:0] bufa;
      full = enc_beats(e);
      bufa = 16'h1000;
      reg_write(2'd2, {1'b0, e[2:0], 28'd0});
      put_word(0, desc0(1'b1, 1'b1, len));
      put_word(1, {16'd0, bufa});
      clear_logs;
      rmode = mode;
      reg_write(2'd0, 32'h0000_0080);
      wait_quiet;
      chk($sformatf("R5 beat count enc=%0d len=%0d", e, len), 64'(nbeats), 64'(len));
      rem = len; k = 0; bad = 0;
      while (rem > 0) begin
         b = (rem < full) ? rem : full;
         if (k < 512 && burst_log[k] != LEN_W'(b)) bad++;
         k++;
         rem -= b;
      end
      chk($sformatf("R4 burst count enc=%0d len=%0d", e, len), 64'(nbursts), 64'(k));
      chk($sformatf("R4 burst sizes enc=%0d len=%0d", e, len), 64'(bad), 64'd0);
      bad = 0;
      for (int i = 0; i < len && i < 1024; i++)
         if (beat_log[i] != bufa + ADDR_W'(4 * i)) bad++;
      chk($sformatf("R5 beat addresses enc=%0d len=%0d", e, len), 64'(bad), 64'd0);
      chk($sformatf("R8 write-back enc=%0d len=%0d", e, len), 64'(mem[0]), 64'(desc0(1'b0, 1'b1, len)));
      chk($sformatf("R9 ring refetch then suspend len=%0d", len), 64'(rd_cnt[0]), 64'd2);
      chk($sformatf("R6 word1 read once len=%0d", len), 64'(rd_cnt[1]), 64'd1);
      rmode = 0;
      reg_write(2'd0, 32'h0);
   endtask

   task automatic run_chain(input int skip);
      int nxt;
      int bad;
      logic [ADDR_W-1:0] exp_a [0:4];
      nxt = (8 + 4 * skip) / 4;
      reg_write(2'd2, 32'h0);
      put_word(0, desc0(1'b1, 1'b0, 2));
      put_word(1, 32'h0000_3000);
      put_word(nxt, desc0(1'b1, 1'b1, 3));
      put_word(nxt + 1, 32'h0000_3100);
      clear_logs;
      reg_write(2'd0, 32'h80 | (skip << 2));
      wait_quiet;
      exp_a[0] = 16'h3000; exp_a[1] = 16'h3004;
      exp_a[2] = 16'h3100; exp_a[3] = 16'h3104; exp_a[4] = 16'h3108;
      chk($sformatf("R7 chain beats skip=%0d", skip), 64'(nbeats), 64'd5);
      bad = 0;
      for (int i = 0; i < 5; i++) if (beat_log[i] != exp_a[i]) bad++;
      chk($sformatf("R7 chain order skip=%0d", skip), 64'(bad), 64'd0);
      chk($sformatf("R7 next descriptor read skip=%0d", skip), 64'(rd_cnt[nxt]), 64'd1);
      chk($sformatf("R7 skipped word not read skip=%0d", skip), 64'(rd_cnt[2]), 64'd0);
      chk($sformatf("R8 both written back skip=%0d", skip), 64'({mem[0][31], mem[nxt][31]}), 64'd0);
      chk($sformatf("R7 ring returns to base skip=%0d", skip), 64'(rd_cnt[0]), 64'd2);
   endtask

   logic [31:0] rd;

   initial begin
      mem_init = 1'b1;
      repeat (3) @(negedge clk);
      mem_init = 1'b0;
      rst_n = 1'b1;

      // R1 reset state
      reg_read(2'd0, rd); chk("R1 mode reset", 64'(rd), 64'h0);
      reg_read(2'd1, rd); chk("R1 card reset reg", 64'(rd), 64'h1);
      reg_read(2'd2, rd); chk("R1 threshold reset", 64'(rd), 64'h0);
      reg_read(2'd3, rd); chk("R1 base reset", 64'(rd), 64'h0);
      chk("R1 card_rst_n high", 64'(card_rst_n), 64'd1);
      chk("R1 idle outputs", 64'({bus_valid, mem_rd_en, mem_wr_en}), 64'd0);

      // R2 / R3 register layout
      reg_write(2'd0, 32'h7FFF_FF7C);
      reg_read(2'd0, rd); chk("R2 R3 mode readback", 64'(rd), 64'h7C);
      reg_write(2'd2, 32'hFFFF_FFFF);
      reg_read(2'd2, rd); chk("R3 threshold field", 64'(rd), 64'h7000_0000);
      for (int e = 0; e < 8; e++) begin
         reg_write(2'd2, {1'b0, e[2:0], 28'd0});
         reg_read(2'd0, rd);
         chk($sformatf("R3 mirror enc=%0d", e), 64'(rd), 64'(32'h7C | (e << 8)));
      end
      reg_write(2'd0, 32'h0000_0700);
      reg_read(2'd0, rd); chk("R3 mirror not writable", 64'(rd[10:8]), 64'd7);
      reg_write(2'd0, 32'h0);

      // R7 base alignment
      reg_write(2'd3, 32'h1234_5677);
      reg_read(2'd3, rd); chk("R7 base aligned", 64'(rd), 64'h5674);
      reg_write(2'd3, 32'h0);

      // R11 card reset
      reg_write(2'd1, 32'h0);
      chk("R11 card held in reset", 64'(card_rst_n), 64'd0);
      reg_read(2'd1, rd); chk("R11 readback 0", 64'(rd), 64'h0);
      reg_write(2'd1, 32'hFFFF_FFFE);
      chk("R11 bit0 only", 64'(card_rst_n), 64'd0);
      reg_write(2'd1, 32'h1);
      chk("R11 card released", 64'(card_rst_n), 64'd1);

      // R4 / R5 / R8 sweep of burst codes and lengths
      for (int e = 0; e < 8; e++) begin
         int lens [0:4];
         lens[0] = 0; lens[1] = 1; lens[2] = 7; lens[3] = 37; lens[4] = enc_beats(e) + 1;
         for (int j = 0; j < 5; j++) run_single(e, lens[j], (e + j) % 2);
      end

      // R7 chains with skip lengths
      reg_write(2'd0, 32'h0);
      run_chain(2);
      reg_write(2'd0, 32'h0);
      for (int i = 0; i < 64; i++) put_word(i, 32'h0);
      run_chain(31);

      // R9 suspend and poll (engine suspended at base with skip 31)
      clear_logs;
      put_word(0, desc0(1'b1, 1'b1, 4));
      put_word(1, 32'h0000_3800);
      repeat (20) @(negedge clk);
      chk("R9 suspended no beats", 64'(nbeats), 64'd0);
      chk("R9 suspended no reads", 64'(rd_cnt[0]), 64'd0);
      reg_write(2'd0, 32'h8000_00FC);
      wait_quiet;
      chk("R9 poll beats", 64'(nbeats), 64'd4);
      chk("R9 poll buffer", 64'(beat_log[0]), 64'h3800);
      chk("R9 poll refetch", 64'(rd_cnt[0]), 64'd2);
      reg_read(2'd0, rd); chk("R2 poll reads zero", 64'(rd[31]), 64'd0);

      // R9 poll while disabled
      reg_write(2'd0, 32'h0);
      put_word(0, desc0(1'b1, 1'b1, 2));
      clear_logs;
      reg_write(2'd0, 32'h8000_0000);
      repeat (10) @(negedge clk);
      chk("R9 poll while disabled", 64'(rd_cnt[0] + nbeats), 64'd0);

      // R10 disable during a stalled beat
      clear_logs;
      put_word(0, desc0(1'b1, 1'b1, 50));
      put_word(1, 32'h0000_4000);
      rmode = 2; manual_ready = 1'b0;
      reg_write(2'd0, 32'h80);
      for (int t = 0; t < 50 && !bus_valid; t++) @(negedge clk);
      chk("R10 transfer started", 64'(bus_valid), 64'd1);
      reg_write(2'd0, 32'h0);
      chk("R10 pending beat held", 64'({bus_valid, 8'(nbeats)}), 64'h100);
      manual_ready = 1'b1;
      @(negedge clk);
      manual_ready = 1'b0;
      chk("R10 stop after beat", 64'({bus_valid, 8'(nbeats)}), 64'h001);
      repeat (10) @(negedge clk);
      chk("R10 no further beats", 64'(nbeats), 64'd1);
      chk("R10 no write-back", 64'(mem[0]), 64'(desc0(1'b1, 1'b1, 50)));
      rmode = 0;

      // R10 re-enable restarts from base
      clear_logs;
      put_word(0, desc0(1'b1, 1'b1, 3));
      reg_write(2'd0, 32'h80);
      wait_quiet;
      chk("R10 restart from base", 64'(nbeats), 64'd3);
      chk("R10 restart address", 64'(beat_log[0]), 64'h4000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule